// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a free-running 32.768 kHz timebase into a periodic event of selectable rate. Each period is a power of two of the timebase, from 4 to 16384 ticks, and is chosen by a 4-bit rate code. On every expiry the block emits a one-cycle flag pulse, which the status logic uses to set its periodic flag. When the periodic-interrupt enable is set, the block also emits a one-cycle interrupt pulse. When the square-wave enable is set, it drives a 50% duty square wave at the same rate.

The timebase reaches the block as a one-clock enable pulse (`tick_32k`) on the system clock. A tick divider counts these pulses whenever the 3-bit divider-control field allows it. Expiries always fall on whole multiples of the period on that count, so the phase stays aligned to period boundaries. A new rate code is adopted only at a period boundary of the code in force.

The controller has four states:
- `ST_STOP`: the generator is off.
- `ST_RESET`: the divider is held in reset.
- `ST_LOW`: the first half of a period, square wave low.
- `ST_HIGH`: the second half of a period, square wave high.

Its transitions are:
- STOP→LOW on enable.
- LOW→HIGH at the half-period point.
- HIGH→LOW at the period boundary, where the event fires.
- LOW/HIGH→STOP on disable.
- any→RESET while divider reset is requested.
- RESET→LOW or RESET→STOP on release, depending on whether the generator is enabled.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, `pf_pulse`, `irq_pulse` and `sqw_out` are all low.
- R2: For an effective code n in 3..15 the period is 2^(n-1) ticks. The event fires on the tick that brings the divider count (ticks counted since the divider was last cleared, modulo 16384) to a multiple of the period.
- R3: Rate codes 1 and 2 are remapped by adding 7, so they give periods of 128 and 256 ticks.
- R4: With rate code 0, or with both `pie_en` and `sqw_en` low, no event fires and `sqw_out` stays low.
- R5: An event shows as `pf_pulse` high for exactly one clock, on the clock after the expiring tick's edge. `irq_pulse` is high in that same clock only if `pie_en` is 1.
- R6: With `sqw_en`=1, `sqw_out` goes high after the tick that brings the count modulo the period to half the period, and goes low after the tick that brings it to 0. With `sqw_en`=0, `sqw_out` is low.
- R7: With `div_ctrl` = 110 or 111 the divider is cleared, no event fires and `sqw_out` is low. After release, the first event comes exactly one period of ticks later.
- R8: With `div_ctrl` = 011, 100 or 101, ticks are ignored and the count is held. With `div_ctrl` at 010 or lower, counting resumes from the held value.
- R9: A rate-code change while running takes effect only at the next period boundary of the code already in force. No earlier boundary of the new code produces an event.
- R10: Enabling the generator part way through a period gives a first event at the next multiple of the period, not one full period after the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-clock enable pulse at the 32.768 kHz rate |
| rate_code | input | CODE_W | Rate-select code; 0 disables |
| div_ctrl | input | 3 | Divider control: 000-010 count, 011-101 hold, 11x reset |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| pf_pulse | output | 1 | One-cycle periodic flag set pulse |
| irq_pulse | output | 1 | One-cycle interrupt request pulse |
| sqw_out | output | 1 | Square-wave output |

## Verification
The hardest situation to reach from the ports is a rate change in mid-period. The old period's boundary must be honoured, and the new, shorter period's boundaries that fall before it must be skipped. The stimulus reaches this case in steps. It first clears the divider, which fixes the tick phase. It then runs to a known count inside a 16-tick period and switches to a 4-tick code. Finally it checks every tick up to and past the old boundary. The held-divider and enable-in-mid-period cases are reached the same way, by counting ticks from a known divider clear.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    localparam int DIVCTL_W = 3;
    localparam logic [DIVCTL_W-1:0] DIV_RUN_MAX = 3'b010;
    localparam int ALIAS_ADD = 7;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RESET = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } rpg_state_e;
endpackage

// File: rtl/rpg_code_remap.sv
module rpg_code_remap
    import rpg_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] eff_o
);
    always_comb begin
        if ((code_i == CODE_W'(1)) || (code_i == CODE_W'(2))) begin
            eff_o = code_i + CODE_W'(ALIAS_ADD);
        end else begin
            eff_o = code_i;
        end
    end
endmodule

// File: rtl/rpg_period_mask.sv
module rpg_period_mask #(
    parameter int CODE_W = 4,
    parameter int DIV_W  = 14
) (
    input  logic [CODE_W-1:0] eff_i,
    output logic [DIV_W-1:0]  mask_o,
    output logic [DIV_W-1:0]  half_o
);
    // mask: period-1 = 2^(n-1)-1 ; half: 2^(n-2)
    for (genvar i = 0; i < DIV_W; i++) begin : g_bit
        assign mask_o[i] = (int'(eff_i) > (i + 1));
        assign half_o[i] = (int'(eff_i) == (i + 2));
    end
endmodule

// File: rtl/rpg_divider.sv
module rpg_divider #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clear_i,
    output logic [DIV_W-1:0] cnt_nxt_o
);
    logic [DIV_W-1:0] cnt_q;

    assign cnt_nxt_o = cnt_q + DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_nxt_o;
        end
    end
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
    import rpg_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_32k,
    input  logic [CODE_W-1:0]   rate_code,
    input  logic [DIVCTL_W-1:0] div_ctrl,
    input  logic                pie_en,
    input  logic                sqw_en,
    output logic                pf_pulse,
    output logic                irq_pulse,
    output logic                sqw_out
);
    localparam int DIV_W = (1 << CODE_W) - 2;

    rpg_state_e        state, state_nxt;
    logic [CODE_W-1:0] eff_in, cur_n;
    logic [DIV_W-1:0]  cnt_nxt, mask_cur, half_cur;
    logic divrst, counting, gen_en, step;
    logic at_bound, at_half, running, evt;
    logic pf_q, irq_q, sqw_q;

    rpg_code_remap #(.CODE_W(CODE_W)) u_remap (
        .code_i (rate_code),
        .eff_o  (eff_in)
    );

    rpg_period_mask #(.CODE_W(CODE_W), .DIV_W(DIV_W)) u_mask (
        .eff_i  (cur_n),
        .mask_o (mask_cur),
        .half_o (half_cur)
    );

    rpg_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .clear_i   (divrst),
        .cnt_nxt_o (cnt_nxt)
    );

    // Qualifiers
    always_comb begin
        divrst   = (div_ctrl[DIVCTL_W-1:DIVCTL_W-2] == 2'b11);
        counting = (div_ctrl <= DIV_RUN_MAX);
        gen_en   = (rate_code != '0) && (pie_en || sqw_en);
        step     = tick_32k && counting && !divrst;
        at_bound = step && ((cnt_nxt & mask_cur) == '0);
        at_half  = step && ((cnt_nxt & mask_cur) == half_cur);
        running  = (state == ST_LOW) || (state == ST_HIGH);
        evt      = running && gen_en && at_bound;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (divrst) begin
            state_nxt = ST_RESET;
        end else begin
            unique case (state)
                ST_RESET: state_nxt = gen_en ? ST_LOW : ST_STOP;
                ST_STOP:  if (gen_en) state_nxt = ST_LOW;
                ST_LOW: begin
                    if (!gen_en)      state_nxt = ST_STOP;
                    else if (at_half) state_nxt = ST_HIGH;
                end
                ST_HIGH: begin
                    if (!gen_en)       state_nxt = ST_STOP;
                    else if (at_bound) state_nxt = ST_LOW;
                end
            endcase
        end
    end

    // State register and active rate latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOP;
            cur_n <= '0;
        end else begin
            state <= state_nxt;
            if (!running || evt) begin
                cur_n <= eff_in;
            end
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q  <= 1'b0;
            irq_q <= 1'b0;
            sqw_q <= 1'b0;
        end else begin
            pf_q  <= evt;
            irq_q <= evt && pie_en;
            sqw_q <= sqw_en && (state_nxt == ST_HIGH);
        end
    end

    assign pf_pulse  = pf_q;
    assign irq_pulse = irq_q;
    assign sqw_out   = sqw_q;

    // Assertions
    a_r5_irq_with_pf: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> pf_pulse);
    a_r5_irq_needs_pie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(pie_en));
    a_r5_pf_single: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pulse |=> !pf_pulse);
    a_r6_sqw_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sqw_en) |-> !sqw_out);
    a_r7_divrst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(divrst) |-> (!pf_pulse && !sqw_out));
    a_r9_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && gen_en && !divrst && !evt) |=> $stable(cur_n));
    a_r3_no_alias_live: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_n != CODE_W'(1)) && (cur_n != CODE_W'(2)));
endmodule

// File: tb/rtc_periodic_gen_bench.sv
module rtc_periodic_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_32k;
    logic [3:0] rate_code;
    logic [2:0] div_ctrl;
    logic       pie_en, sqw_en;
    logic       pf_pulse, irq_pulse, sqw_out;

    int n_cmp = 0;
    int n_bad = 0;
    int k = 0;  // bench model of divider count

    always #5 clk = ~clk;

    rtc_periodic_gen u_rtc_periodic_gen (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
        .div_ctrl(div_ctrl), .pie_en(pie_en), .sqw_en(sqw_en),
        .pf_pulse(pf_pulse), .irq_pulse(irq_pulse), .sqw_out(sqw_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at count %0d: actual %0d expected %0d", req, what, k, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_tick(output logic p, output logic i, output logic s);
        tick_32k = 1'b1;
        @(negedge clk);
        tick_32k = 1'b0;
        p = pf_pulse; i = irq_pulse; s = sqw_out;
        @(negedge clk);
    endtask

    task automatic setup(input logic [3:0] code, input logic pie, input logic sqw);
        rate_code = code; pie_en = pie; sqw_en = sqw;
    endtask

    task automatic clear_div();
        div_ctrl = 3'b110;
        settle();
        div_ctrl = 3'b010;
        k = 0;
        settle();
    endtask

    // sqw_mode: 0 expect low, 1 expect half-period pattern, 2 unchecked
    task automatic run_ticks(input int n, input int per, input bit ev, input bit irq_en,
                             input int sqw_mode, input string req);
        logic p, i, s;
        for (int j = 0; j < n; j++) begin
            int ep;
            do_tick(p, i, s);
            k++;
            ep = (ev && (k % per == 0)) ? 1 : 0;
            chk(req, "pf_pulse", int'(p), ep);
            chk(req, "irq_pulse", int'(i), (ep == 1 && irq_en) ? 1 : 0);
            if (sqw_mode == 1)      chk(req, "sqw_out", int'(s), ((k % per) >= per / 2) ? 1 : 0);
            else if (sqw_mode == 0) chk(req, "sqw_out", int'(s), 0);
        end
    endtask

    task automatic t_reset();
        chk("R1", "pf_pulse", int'(pf_pulse), 0);
        chk("R1", "irq_pulse", int'(irq_pulse), 0);
        chk("R1", "sqw_out", int'(sqw_out), 0);
    endtask

    task automatic t_basic();
        setup(4'd6, 1'b1, 1'b1); clear_div();
        run_ticks(96, 32, 1, 1, 1, "R2_R5_R6");
    endtask

    task automatic t_min_max();
        setup(4'd3, 1'b1, 1'b1); clear_div();
        run_ticks(16, 4, 1, 1, 1, "R2");
        setup(4'd15, 1'b1, 1'b1); clear_div();
        run_ticks(16384, 16384, 1, 1, 1, "R2");
    endtask

    task automatic t_alias();
        setup(4'd1, 1'b1, 1'b1); clear_div();
        run_ticks(256, 128, 1, 1, 1, "R3");
        setup(4'd2, 1'b1, 1'b1); clear_div();
        run_ticks(512, 256, 1, 1, 1, "R3");
    endtask

    task automatic t_enables();
        setup(4'd4, 1'b0, 1'b1); clear_div();
        run_ticks(24, 8, 1, 0, 1, "R5");
        setup(4'd4, 1'b1, 1'b0); clear_div();
        run_ticks(24, 8, 1, 1, 0, "R6");
    endtask

    task automatic t_off();
        setup(4'd0, 1'b1, 1'b1); clear_div();
        run_ticks(32, 8, 0, 0, 0, "R4");
        setup(4'd5, 1'b0, 1'b0); clear_div();
        run_ticks(32, 16, 0, 0, 0, "R4");
    endtask

    task automatic t_freeze();
        logic p, i, s;
        setup(4'd4, 1'b1, 1'b1); clear_div();
        run_ticks(10, 8, 1, 1, 1, "R8");
        for (int v = 3; v <= 5; v++) begin
            div_ctrl = 3'(v);
            settle();
            for (int j = 0; j < 8; j++) begin
                do_tick(p, i, s);
                chk("R8", "pf_pulse held", int'(p), 0);
                chk("R8", "sqw_out held", int'(s), 0);
            end
        end
        div_ctrl = 3'b010;
        settle();
        run_ticks(14, 8, 1, 1, 1, "R8");
    endtask

    task automatic t_divrst();
        logic p, i, s;
        setup(4'd4, 1'b1, 1'b1); clear_div();
        run_ticks(12, 8, 1, 1, 1, "R7");
        div_ctrl = 3'b111;
        settle();
        for (int j = 0; j < 10; j++) begin
            do_tick(p, i, s);
            chk("R7", "pf_pulse in reset", int'(p), 0);
            chk("R7", "sqw_out in reset", int'(s), 0);
        end
        div_ctrl = 3'b000;
        k = 0;
        settle();
        run_ticks(16, 8, 1, 1, 1, "R7");
    endtask

    task automatic t_ratechg();
        setup(4'd5, 1'b1, 1'b1); clear_div();
        run_ticks(20, 16, 1, 1, 1, "R9");
        rate_code = 4'd3;
        settle();
        run_ticks(12, 16, 1, 1, 1, "R9");
        run_ticks(8, 4, 1, 1, 1, "R9");
    endtask

    task automatic t_align();
        setup(4'd5, 1'b0, 1'b0); clear_div();
        run_ticks(5, 16, 0, 0, 0, "R10");
        pie_en = 1'b1; sqw_en = 1'b1;
        settle();
        run_ticks(27, 16, 1, 1, 1, "R10");
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; tick_32k = 1'b0; rate_code = 4'd0;
        div_ctrl = 3'b010; pie_en = 1'b0; sqw_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_min_max();
        t_alias();
        t_enables();
        t_off();
        t_freeze();
        t_divrst();
        t_ratechg();
        t_align();
        finish_run();
    end
endmodule